// File: doc/BRIEF.md
# Packed Pixel Formatting Unit

The unit reformats packed pixel data between fixed-point and byte forms. A three-bit operation code picks one of five transforms. Three of them are packs: each lane of source B is scaled by a variable left shift, then shifted right by a fixed amount that depends on the operation, then clamped into a narrower range. The other two are byte rearrangements. One widens bytes into 16-bit fixed point, and the other interleaves the bytes of two 32-bit words.

The datapath is combinational. A single register stage follows it, and that stage loads whenever the valid strobe is high. A result therefore appears one clock after its operands. Nothing is decoded here: the operands, the operation and the scale all come from the surrounding pipeline.

Top module: `pxf_fmt_unit`

## Requirements
- R1: While `rst_i` is high at a rising edge, `valid_o` and `result_o` are cleared to zero after that edge. This holds even when `valid_i` is high.
- R2: `valid_o` equals the `valid_i` sampled at the previous rising edge. `result_o` loads only on an edge where `valid_i` is high and otherwise keeps its value.
- R3: Op code 0 (byte pack). Only `scale_i[3:0]` is used. Each signed 16-bit lane i of B is shifted left by that amount, then arithmetically right by 7, then clamped to 0..255. The result goes to `result_o[8i+7:8i]`, and `result_o[63:32]` is zero.
- R4: Op code 0 clamps a negative lane to 0 and a lane above 255 to 255. `scale_i[4]` has no effect on the result.
- R5: Op code 1 (accumulate pack). The result starts as A shifted left by 8, with bits [7:0] and [39:32] forced to zero. Each signed 32-bit lane i of B is shifted left by the 5-bit scale, then right by 23, then clamped to 0..255. That byte goes to bits [32i+7:32i].
- R6: Op code 1 clamps a negative lane to 0 and a lane above 255 to 255.
- R7: Op code 2 (fixed pack). Each signed 32-bit lane i of B is shifted left by the 5-bit scale, then right by 16, then saturated to -32768..32767. The result goes to `result_o[16i+15:16i]`, and `result_o[63:32]` is zero.
- R8: Op code 3 (expand). Unsigned byte i of `b_i[31:0]` is shifted left by 4 and placed in 16-bit lane i, zero-extended.
- R9: Op code 4 (merge). Byte i of `b_i[31:0]` goes to result byte 2i. Byte i of `a_i[31:0]` goes to result byte 2i+1.
- R10: Op codes 5, 6 and 7 produce an all-zero result.
- R11: Scaled intermediates never wrap. At scale 31 a positive 32-bit lane still saturates high and a negative lane still clamps low. At scale 15 a positive 16-bit lane saturates to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands valid strobe |
| op_i | input | 3 | Operation code (0..4 defined) |
| a_i | input | 64 | Source A |
| b_i | input | 64 | Source B |
| scale_i | input | 5 | Left-shift scale factor |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 64 | Registered formatted result |

## Verification
The bench builds the unit with its default intermediate width of 64 bits. At that width, scale values up to 31 on 32-bit lanes can be reached without wrap, and the bench drives those extreme scales with both maximal positive and maximal negative lanes. Directed vectors sit exactly on the clamp and saturation limits of every pack mode. Toggling `scale_i[4]` exercises the byte pack, which must ignore that bit. Random operands and op codes, including the three undefined codes, are mixed with idle cycles and a mid-run reset, so that the hold and clear behaviour of the register stage is exercised as well.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

    localparam int DATA_W  = 64;
    localparam int HALF_W  = 32;
    localparam int SCALE_W = 5;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PACK_BYTE  = 3'd0,
        OP_PACK_ACCUM = 3'd1,
        OP_PACK_FIXED = 3'd2,
        OP_EXPAND     = 3'd3,
        OP_MERGE      = 3'd4
    } pxf_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] pack_byte;
        logic [DATA_W-1:0] pack_accum;
        logic [DATA_W-1:0] pack_fixed;
        logic [DATA_W-1:0] expand;
        logic [DATA_W-1:0] merge;
    } pxf_cand_t;

    function automatic logic [DATA_W-1:0] widen_half(input logic [HALF_W-1:0] x);
        return {{(DATA_W-HALF_W){1'b0}}, x};
    endfunction

endpackage

// File: rtl/pxf_lane_sat.sv
module pxf_lane_sat #(
    parameter int IN_W       = 16,
    parameter int WIDE_W     = 64,
    parameter int SCALE_W    = 5,
    parameter int RSHIFT     = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]    lane_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [OUT_W-1:0]   sat_o
);
    localparam longint HI_L = SIGNED_OUT ? (longint'(1) <<< (OUT_W-1)) - longint'(1)
                                         : (longint'(1) <<< OUT_W) - longint'(1);
    localparam longint LO_L = SIGNED_OUT ? -(longint'(1) <<< (OUT_W-1)) : longint'(0);
    localparam logic signed [WIDE_W-1:0] HI = WIDE_W'(HI_L);
    localparam logic signed [WIDE_W-1:0] LO = WIDE_W'(LO_L);

    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] shifted;

    assign wide    = {{(WIDE_W-IN_W){lane_i[IN_W-1]}}, lane_i};
    assign shifted = (wide <<< scale_i) >>> RSHIFT;

    always_comb begin
        if (shifted > HI)      sat_o = HI[OUT_W-1:0];
        else if (shifted < LO) sat_o = LO[OUT_W-1:0];
        else                   sat_o = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/pxf_pack_stage.sv
module pxf_pack_stage
    import pxf_pkg::*;
#(
    parameter int WIDE_W = 64
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [DATA_W-1:0]  pack_byte_o,
    output logic [DATA_W-1:0]  pack_accum_o,
    output logic [DATA_W-1:0]  pack_fixed_o
);
    localparam int N16 = DATA_W / 16;
    localparam int N32 = DATA_W / 32;

    logic [HALF_W-1:0] byte_word;
    logic [HALF_W-1:0] fixed_word;
    logic [DATA_W-1:0] accum_base;
    logic [DATA_W-1:0] accum_ins;
    logic [DATA_W-1:0] accum_mask;

    for (genvar i = 0; i < N16; i++) begin : g_byte_lane
        pxf_lane_sat #(
            .IN_W(16), .WIDE_W(WIDE_W), .SCALE_W(4),
            .RSHIFT(7), .OUT_W(8), .SIGNED_OUT(1'b0)
        ) u_sat (
            .lane_i (b_i[16*i +: 16]),
            .scale_i(scale_i[3:0]),
            .sat_o  (byte_word[8*i +: 8])
        );
    end

    for (genvar j = 0; j < N32; j++) begin : g_word_lane
        logic [7:0] acc_byte;

        pxf_lane_sat #(
            .IN_W(32), .WIDE_W(WIDE_W), .SCALE_W(SCALE_W),
            .RSHIFT(23), .OUT_W(8), .SIGNED_OUT(1'b0)
        ) u_acc (
            .lane_i (b_i[32*j +: 32]),
            .scale_i(scale_i),
            .sat_o  (acc_byte)
        );

        pxf_lane_sat #(
            .IN_W(32), .WIDE_W(WIDE_W), .SCALE_W(SCALE_W),
            .RSHIFT(16), .OUT_W(16), .SIGNED_OUT(1'b1)
        ) u_fix (
            .lane_i (b_i[32*j +: 32]),
            .scale_i(scale_i),
            .sat_o  (fixed_word[16*j +: 16])
        );

        assign accum_mask[32*j +: 32] = 32'hFFFF_FF00;
        assign accum_ins [32*j +: 32] = {24'h0, acc_byte};
    end

    assign accum_base   = (a_i << 8) & accum_mask;
    assign pack_byte_o  = widen_half(byte_word);
    assign pack_fixed_o = widen_half(fixed_word);
    assign pack_accum_o = accum_base | accum_ins;
endmodule

// File: rtl/pxf_byte_shuffle.sv
module pxf_byte_shuffle
    import pxf_pkg::*;
(
    input  logic [HALF_W-1:0] a_lo_i,
    input  logic [HALF_W-1:0] b_lo_i,
    output logic [DATA_W-1:0] expand_o,
    output logic [DATA_W-1:0] merge_o
);
    localparam int NBYTES = HALF_W / 8;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign expand_o[16*i +: 16]    = {4'h0, b_lo_i[8*i +: 8], 4'h0};
        assign merge_o [16*i +: 8]     = b_lo_i[8*i +: 8];
        assign merge_o [16*i + 8 +: 8] = a_lo_i[8*i +: 8];
    end
endmodule

// File: rtl/pxf_fmt_unit.sv
module pxf_fmt_unit
    import pxf_pkg::*;
#(
    parameter int WIDE_W = 64
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                valid_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [SCALE_W-1:0]  scale_i,
    output logic                valid_o,
    output logic [DATA_W-1:0]   result_o
);
    pxf_cand_t         cand;
    logic [DATA_W-1:0] sel_d;
    pxf_op_e           op_q;

    assign op_q = pxf_op_e'(op_i);

    pxf_pack_stage #(.WIDE_W(WIDE_W)) u_pack (
        .a_i         (a_i),
        .b_i         (b_i),
        .scale_i     (scale_i),
        .pack_byte_o (cand.pack_byte),
        .pack_accum_o(cand.pack_accum),
        .pack_fixed_o(cand.pack_fixed)
    );

    pxf_byte_shuffle u_shuf (
        .a_lo_i  (a_i[HALF_W-1:0]),
        .b_lo_i  (b_i[HALF_W-1:0]),
        .expand_o(cand.expand),
        .merge_o (cand.merge)
    );

    always_comb begin
        case (op_q)
            OP_PACK_BYTE:  sel_d = cand.pack_byte;
            OP_PACK_ACCUM: sel_d = cand.pack_accum;
            OP_PACK_FIXED: sel_d = cand.pack_fixed;
            OP_EXPAND:     sel_d = cand.expand;
            OP_MERGE:      sel_d = cand.merge;
            default:       sel_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o  <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) result_o <= sel_d;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!valid_o && result_o == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> valid_o);

    // R2
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> (!valid_o && $stable(result_o)));

    // R3
    byte_pack_upper_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i == OP_PACK_BYTE) |=> (result_o[DATA_W-1:HALF_W] == '0));

    // R7
    fixed_pack_upper_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i == OP_PACK_FIXED) |=> (result_o[DATA_W-1:HALF_W] == '0));

    // R8
    expand_nibble_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i == OP_EXPAND) |=> ((result_o & 64'hF00F_F00F_F00F_F00F) == '0));

    // R5
    accum_zero_byte_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i == OP_PACK_ACCUM && b_i == '0) |=>
            (result_o[7:0] == 8'h0 && result_o[39:32] == 8'h0));

    // R10
    undefined_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i > OP_MERGE) |=> (result_o == '0));
endmodule

// File: tb/tb_pxf_fmt_unit.sv
module tb_pxf_fmt_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [63:0] a_i, b_i;
    logic [4:0]  scale_i;
    logic        valid_o;
    logic [63:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        exp_v;
    logic [63:0] exp_r;

    always #2.5 clk = ~clk;

    pxf_fmt_unit dut (
        .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .scale_i(scale_i),
        .valid_o(valid_o), .result_o(result_o)
    );

    function automatic longint clampv(input longint x, input longint lo, input longint hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [4:0] s);
        logic [63:0] r;
        longint x;
        r = 64'h0;
        case (op)
            3'd0: for (int i = 0; i < 4; i++) begin
                x = longint'($signed(b[16*i +: 16]));
                x = (x <<< s[3:0]) >>> 7;
                x = clampv(x, 0, 255);
                r[8*i +: 8] = x[7:0];
            end
            3'd1: begin
                r = a << 8;
                r[7:0] = 8'h0;
                r[39:32] = 8'h0;
                for (int i = 0; i < 2; i++) begin
                    x = longint'($signed(b[32*i +: 32]));
                    x = (x <<< s) >>> 23;
                    x = clampv(x, 0, 255);
                    r[32*i +: 8] = x[7:0];
                end
            end
            3'd2: for (int i = 0; i < 2; i++) begin
                x = longint'($signed(b[32*i +: 32]));
                x = (x <<< s) >>> 16;
                x = clampv(x, -32768, 32767);
                r[16*i +: 16] = x[15:0];
            end
            3'd3: for (int i = 0; i < 4; i++)
                r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
            3'd4: for (int i = 0; i < 4; i++) begin
                r[16*i +: 8]     = b[8*i +: 8];
                r[16*i + 8 +: 8] = a[8*i +: 8];
            end
            default: r = 64'h0;
        endcase
        return r;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (valid_o !== exp_v || result_o !== exp_r) begin
            fails++;
            $display("FAIL %s actual v=%0b r=%h expected v=%0b r=%h",
                     tag, valid_o, result_o, exp_v, exp_r);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare at next fall.
    task automatic step(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] s, input logic v, input string tag);
        op_i = op; a_i = a; b_i = b; scale_i = s; valid_i = v;
        @(posedge clk);
        if (rst) begin
            exp_v = 1'b0;
            exp_r = 64'h0;
        end else begin
            exp_v = v;
            if (v) exp_r = model(op, a, b, s);
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        valid_i = 1'b1; op_i = 3'd4; a_i = 64'hDEAD_BEEF_0123_4567; b_i = '1; scale_i = 5'd3;
        exp_v = 1'b0; exp_r = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 1'b0;

        // R3 basic and R4 clamp bounds, scale bit 4 ignored
        step(3'd0, 64'h0, 64'h7FFF_FF80_0080_0100, 5'd0, 1'b1, "R3");
        step(3'd0, 64'h0, 64'h0040_8000_0001_00FF, 5'd2, 1'b1, "R3");
        step(3'd0, 64'h0, 64'h0100_FFFF_0200_0081, 5'd1, 1'b1, "R4");
        step(3'd0, 64'h0, 64'h0100_FFFF_0200_0081, 5'd17, 1'b1, "R4");
        step(3'd0, 64'h0, 64'h0001_0001_FFFF_0000, 5'd15, 1'b1, "R11");
        // R5 / R6
        step(3'd1, 64'h1122_3344_5566_7788, 64'h0080_0000_0000_0000, 5'd0, 1'b1, "R5");
        step(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 5'd0, 1'b1, "R6");
        step(3'd1, 64'hA5A5_A5A5_5A5A_5A5A, 64'h0001_0000_0000_8000, 5'd8, 1'b1, "R6");
        step(3'd1, 64'h0, 64'h8000_0000_0000_0001, 5'd31, 1'b1, "R11");
        // R7
        step(3'd2, 64'h0, 64'h7FFF_FFFF_8000_0000, 5'd0, 1'b1, "R7");
        step(3'd2, 64'h0, 64'h7FFF_FFFF_8000_0000, 5'd1, 1'b1, "R7");
        step(3'd2, 64'h0, 64'h0000_4000_FFFF_C000, 5'd2, 1'b1, "R7");
        step(3'd2, 64'h0, 64'h0000_0001_FFFF_FFFF, 5'd31, 1'b1, "R11");
        // R8 / R9
        step(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FF80_01A5, 5'd9, 1'b1, "R8");
        step(3'd4, 64'hFFFF_FFFF_A1A2_A3A4, 64'hEEEE_EEEE_B1B2_B3B4, 5'd0, 1'b1, "R9");
        // R10
        for (int k = 5; k < 8; k++)
            step(3'(k), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 5'd4, 1'b1, "R10");
        // R2: idle cycles hold result while inputs change
        step(3'd4, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 5'd0, 1'b1, "R9");
        step(3'd0, 64'h0, 64'h7FFF_7FFF_7FFF_7FFF, 5'd5, 1'b0, "R2");
        step(3'd6, 64'h0, 64'h0, 5'd0, 1'b0, "R2");
        step(3'd3, 64'h0, 64'h0000_0000_0102_0304, 5'd0, 1'b1, "R2");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  op;
            logic [63:0] a, b;
            logic [4:0]  s;
            logic        v;
            op = 3'($urandom_range(0, 7));
            a  = {$urandom(), $urandom()};
            b  = {$urandom(), $urandom()};
            s  = 5'($urandom());
            v  = ($urandom_range(0, 3) != 0);
            step(op, a, b, s, v, v ? tag_of(op) : "R2");
        end

        // mid-run reset
        rst = 1'b1;
        step(3'd1, 64'h1, 64'h7FFF_FFFF_7FFF_FFFF, 5'd3, 1'b1, "R1");
        rst = 1'b0;
        step(3'd3, 64'h0, 64'h0000_0000_FFFF_FFFF, 5'd0, 1'b1, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule